// File: doc/BRIEF.md
# Front-Panel Display and Switch Port

This block is a small programmed-I/O peripheral that models an operator panel. The host side drives a byte-wide data bus and one of five single-cycle strobes: select, mode command, data write, data read and status sense. Data writes fill a 32-bit lamp register one byte at a time. Data reads return the two bytes of a 16-bit switch input, alternating between them.

The display side keeps its own byte pointer. A mode command picks whether this pointer stays fixed or steps forward after every write. The switch side keeps a separate one-bit pointer that flips after every read. A select strobe sends both pointers back to byte 0. Read and status data appear on the output bus in the same cycle as the strobe. At most one strobe is active in any clock.

Top module: `panel_io_dev`

## Requirements
- R1: Synchronous active-high reset clears the display register to zero, selects fixed (non-stepping) mode and sets both byte pointers to 0.
- R2: A select strobe sets the display byte pointer and the switch byte pointer to 0. After it, the next write lands in byte 0 and the next read returns switch bits 7:0.
- R3: On a command strobe only data bits 7:6 count. 01 selects stepping mode, 10 selects fixed mode, 11 inverts the current mode, and 00 leaves the mode unchanged. Bits 5:0 are ignored.
- R4: A write strobe puts the data byte into display byte p, at bits 8p+7 down to 8p, where p is the display pointer. The other three bytes are unchanged. The display does not change without a write strobe.
- R5: In stepping mode the display pointer advances by one after each write, and wraps from 3 to 0.
- R6: In fixed mode the display pointer does not move on a write.
- R7: A read strobe drives the switch byte selected by the switch pointer onto the output bus in the same cycle. Pointer 0 selects bits 7:0 and pointer 1 selects bits 15:8. The switch input is sampled in that cycle, and the pointer then flips. Reads do not move the display pointer, and writes do not move the switch pointer.
- R8: A status strobe drives 0x80 onto the output bus in the same cycle and changes no state.
- R9: When neither a read strobe nor a status strobe is active, the output bus is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sel_stb | input | 1 | Select strobe, resets both byte pointers |
| cmd_stb | input | 1 | Mode command strobe, code in bus_wdata[7:6] |
| wr_stb | input | 1 | Display byte write strobe |
| rd_stb | input | 1 | Switch byte read strobe |
| stat_stb | input | 1 | Status sense strobe |
| bus_wdata | input | 8 | Host data byte for command and write |
| switch_in | input | 16 | Switch register value |
| bus_rdata | output | 8 | Read or status byte, zero when idle |
| disp_out | output | 32 | Display register contents |

## Verification
The hardest state to reach is a mode inversion taken from each of the two starting modes, followed by pointer wrap-around. Reaching it needs a chain of commands, selects and at least five writes, and the only effect that can be seen is which byte of the display changes. The bench therefore sweeps all four command codes from both starting modes, with varied don't-care low bits. Each sweep ends with a run of writes that must either pile into one byte or walk through all four bytes and wrap. A reference model in the bench predicts every display and read value.

// File: rtl/panel_pkg.sv
package panel_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [1:0] {
        MC_KEEP  = 2'b00,
        MC_STEP  = 2'b01,
        MC_FIXED = 2'b10,
        MC_FLIP  = 2'b11
    } mode_cmd_e;

    typedef struct packed {
        logic sel;
        logic cmd;
        logic wr;
        logic rd;
        logic stat;
    } strobe_t;

    localparam logic [BYTE_W-1:0] STATUS_BYTE = 8'h80;

    // mode after a command; 1 = stepping
    function automatic logic mode_after(input logic cur, input mode_cmd_e code);
        logic nxt;
        case (code)
            MC_STEP:  nxt = 1'b1;
            MC_FIXED: nxt = 1'b0;
            MC_FLIP:  nxt = ~cur;
            default:  nxt = cur;
        endcase
        return nxt;
    endfunction

endpackage

// File: rtl/panel_mode_ctl.sv
module panel_mode_ctl
    import panel_pkg::*;
#(
    parameter int DATA_W = BYTE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_stb,
    input  logic [DATA_W-1:0] cmd_byte,
    output logic              step_mode
);
    localparam int CODE_LSB = DATA_W - 2;

    mode_cmd_e code;
    assign code = mode_cmd_e'(cmd_byte[DATA_W-1:CODE_LSB]);

    always_ff @(posedge clk) begin
        if (rst) begin
            step_mode <= 1'b0;
        end else if (cmd_stb) begin
            step_mode <= mode_after(step_mode, code);
        end
    end
endmodule

// File: rtl/panel_disp_reg.sv
module panel_disp_reg
    import panel_pkg::*;
#(
    parameter int DATA_W     = BYTE_W,
    parameter int DISP_BYTES = 4,
    localparam int PTR_W     = (DISP_BYTES > 1) ? $clog2(DISP_BYTES) : 1,
    localparam int DISP_W    = DATA_W * DISP_BYTES
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sel_stb,
    input  logic              wr_stb,
    input  logic              step_mode,
    input  logic [DATA_W-1:0] wr_byte,
    output logic [PTR_W-1:0]  wr_ptr,
    output logic [DISP_W-1:0] disp
);
    localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DISP_BYTES - 1);

    logic [PTR_W-1:0] ptr_next;
    assign ptr_next = (wr_ptr == LAST_PTR) ? '0 : wr_ptr + PTR_W'(1);

    always_ff @(posedge clk) begin
        if (rst || sel_stb) begin
            wr_ptr <= '0;
        end else if (wr_stb && step_mode) begin
            wr_ptr <= ptr_next;
        end
    end

    for (genvar b = 0; b < DISP_BYTES; b++) begin : g_lane
        logic lane_we;
        assign lane_we = wr_stb && (wr_ptr == PTR_W'(b));
        always_ff @(posedge clk) begin
            if (rst) begin
                disp[b*DATA_W +: DATA_W] <= '0;
            end else if (lane_we) begin
                disp[b*DATA_W +: DATA_W] <= wr_byte;
            end
        end
    end
endmodule

// File: rtl/panel_sw_read.sv
module panel_sw_read
    import panel_pkg::*;
#(
    parameter int DATA_W   = BYTE_W,
    parameter int SW_BYTES = 2,
    localparam int SPTR_W  = (SW_BYTES > 1) ? $clog2(SW_BYTES) : 1,
    localparam int SW_W    = DATA_W * SW_BYTES
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sel_stb,
    input  logic              rd_stb,
    input  logic              stat_stb,
    input  logic [SW_W-1:0]   switches,
    output logic [SPTR_W-1:0] rd_ptr,
    output logic [DATA_W-1:0] rdata
);
    localparam logic [SPTR_W-1:0] LAST_SPTR = SPTR_W'(SW_BYTES - 1);

    logic [DATA_W-1:0] sw_lane [SW_BYTES];

    for (genvar b = 0; b < SW_BYTES; b++) begin : g_sw
        assign sw_lane[b] = switches[b*DATA_W +: DATA_W];
    end

    always_ff @(posedge clk) begin
        if (rst || sel_stb) begin
            rd_ptr <= '0;
        end else if (rd_stb) begin
            rd_ptr <= (rd_ptr == LAST_SPTR) ? '0 : rd_ptr + SPTR_W'(1);
        end
    end

    always_comb begin
        if (rd_stb) begin
            rdata = sw_lane[rd_ptr];
        end else if (stat_stb) begin
            rdata = STATUS_BYTE;
        end else begin
            rdata = '0;
        end
    end
endmodule

// File: rtl/panel_io_dev.sv
module panel_io_dev
    import panel_pkg::*;
#(
    parameter int DATA_W     = BYTE_W,
    parameter int DISP_BYTES = 4,
    parameter int SW_BYTES   = 2,
    localparam int PTR_W     = (DISP_BYTES > 1) ? $clog2(DISP_BYTES) : 1,
    localparam int SPTR_W    = (SW_BYTES > 1) ? $clog2(SW_BYTES) : 1
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         sel_stb,
    input  logic                         cmd_stb,
    input  logic                         wr_stb,
    input  logic                         rd_stb,
    input  logic                         stat_stb,
    input  logic [DATA_W-1:0]            bus_wdata,
    input  logic [DATA_W*SW_BYTES-1:0]   switch_in,
    output logic [DATA_W-1:0]            bus_rdata,
    output logic [DATA_W*DISP_BYTES-1:0] disp_out
);
    strobe_t           stb;
    logic              step_mode;
    logic [PTR_W-1:0]  wr_ptr;
    logic [SPTR_W-1:0] rd_ptr;

    assign stb = '{sel: sel_stb, cmd: cmd_stb, wr: wr_stb, rd: rd_stb, stat: stat_stb};

    panel_mode_ctl #(.DATA_W(DATA_W)) u_mode (
        .clk       (clk),
        .rst       (rst),
        .cmd_stb   (stb.cmd),
        .cmd_byte  (bus_wdata),
        .step_mode (step_mode)
    );

    panel_disp_reg #(.DATA_W(DATA_W), .DISP_BYTES(DISP_BYTES)) u_disp (
        .clk       (clk),
        .rst       (rst),
        .sel_stb   (stb.sel),
        .wr_stb    (stb.wr),
        .step_mode (step_mode),
        .wr_byte   (bus_wdata),
        .wr_ptr    (wr_ptr),
        .disp      (disp_out)
    );

    panel_sw_read #(.DATA_W(DATA_W), .SW_BYTES(SW_BYTES)) u_sw (
        .clk      (clk),
        .rst      (rst),
        .sel_stb  (stb.sel),
        .rd_stb   (stb.rd),
        .stat_stb (stb.stat),
        .switches (switch_in),
        .rd_ptr   (rd_ptr),
        .rdata    (bus_rdata)
    );
endmodule

// File: rtl/panel_io_dev_chk.sv
module panel_io_dev_chk #(
    parameter int DATA_W     = 8,
    parameter int DISP_BYTES = 4,
    parameter int PTR_W      = 2,
    parameter int SPTR_W     = 1
) (
    input logic                         clk,
    input logic                         rst,
    input logic                         sel_stb,
    input logic                         cmd_stb,
    input logic                         wr_stb,
    input logic                         rd_stb,
    input logic                         stat_stb,
    input logic [DATA_W-1:0]            bus_wdata,
    input logic [DATA_W-1:0]            bus_rdata,
    input logic [DATA_W*DISP_BYTES-1:0] disp_out,
    input logic                         step_mode,
    input logic [PTR_W-1:0]             wr_ptr,
    input logic [SPTR_W-1:0]            rd_ptr
);
    logic [DATA_W*DISP_BYTES-1:0] disp_prev;
    logic [DISP_BYTES-1:0]        lane_diff;

    always_ff @(posedge clk) disp_prev <= disp_out;

    always_comb begin
        for (int b = 0; b < DISP_BYTES; b++) begin
            lane_diff[b] = disp_out[b*DATA_W +: DATA_W] != disp_prev[b*DATA_W +: DATA_W];
        end
    end

    AST_RESET_STATE: assert property (@(posedge clk)
        rst |=> (disp_out == '0 && !step_mode && wr_ptr == '0 && rd_ptr == '0)); // R1

    AST_SELECT_HOMES: assert property (@(posedge clk) disable iff (rst)
        sel_stb |=> (wr_ptr == '0 && rd_ptr == '0)); // R2

    AST_CMD_KEEP: assert property (@(posedge clk) disable iff (rst)
        (cmd_stb && bus_wdata[DATA_W-1 -: 2] == 2'b00) |=> $stable(step_mode)); // R3

    AST_CMD_FLIP: assert property (@(posedge clk) disable iff (rst)
        (cmd_stb && bus_wdata[DATA_W-1 -: 2] == 2'b11) |=> (step_mode != $past(step_mode))); // R3

    AST_ONE_LANE: assert property (@(posedge clk) disable iff (rst)
        wr_stb |=> ($countones(lane_diff) <= 1)); // R4

    AST_DISP_HOLD: assert property (@(posedge clk) disable iff (rst)
        !wr_stb |=> $stable(disp_out)); // R4

    AST_STEP_ADV: assert property (@(posedge clk) disable iff (rst)
        (wr_stb && step_mode) |=> (wr_ptr != $past(wr_ptr))); // R5

    AST_FIXED_PTR: assert property (@(posedge clk) disable iff (rst)
        (wr_stb && !step_mode) |=> $stable(wr_ptr)); // R6

    AST_READ_FLIPS: assert property (@(posedge clk) disable iff (rst)
        rd_stb |=> (rd_ptr != $past(rd_ptr))); // R7

    AST_STATUS_BYTE: assert property (@(posedge clk) disable iff (rst)
        stat_stb |-> (bus_rdata == 8'h80)); // R8

    AST_IDLE_BUS: assert property (@(posedge clk) disable iff (rst)
        (!rd_stb && !stat_stb) |-> (bus_rdata == '0)); // R9
endmodule

bind panel_io_dev panel_io_dev_chk #(
    .DATA_W(DATA_W), .DISP_BYTES(DISP_BYTES), .PTR_W(PTR_W), .SPTR_W(SPTR_W)
) u_chk (
    .clk(clk), .rst(rst), .sel_stb(sel_stb), .cmd_stb(cmd_stb), .wr_stb(wr_stb),
    .rd_stb(rd_stb), .stat_stb(stat_stb), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .disp_out(disp_out), .step_mode(step_mode), .wr_ptr(wr_ptr), .rd_ptr(rd_ptr)
);

// File: tb/panel_io_dev_test.sv
module panel_io_dev_test;
    localparam int CLK_PERIOD = 10;
    localparam int K_SEL = 0, K_CMD = 1, K_WR = 2, K_RD = 3, K_ST = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sel_stb = 0, cmd_stb = 0, wr_stb = 0, rd_stb = 0, stat_stb = 0;
    logic [7:0]  bus_wdata = '0;
    logic [15:0] switch_in = '0;
    logic [7:0]  bus_rdata;
    logic [31:0] disp_out;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // reference model
    logic [31:0] m_disp = '0;
    logic        m_step = 0;
    int          m_wp   = 0;
    int          m_sp   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    panel_io_dev uut (
        .clk(clk), .rst(rst), .sel_stb(sel_stb), .cmd_stb(cmd_stb), .wr_stb(wr_stb),
        .rd_stb(rd_stb), .stat_stb(stat_stb), .bus_wdata(bus_wdata), .switch_in(switch_in),
        .bus_rdata(bus_rdata), .disp_out(disp_out)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // one strobe cycle; checks bus in the strobe cycle and display afterwards
    task automatic op(input int kind, input logic [7:0] d, input string req);
        logic [7:0] exp_rd;
        logic [7:0] seen;
        case (kind)
            K_RD:    exp_rd = (m_sp == 0) ? switch_in[7:0] : switch_in[15:8];
            K_ST:    exp_rd = 8'h80;
            default: exp_rd = 8'h00;
        endcase
        @(negedge clk);
        bus_wdata = d;
        sel_stb  = (kind == K_SEL);
        cmd_stb  = (kind == K_CMD);
        wr_stb   = (kind == K_WR);
        rd_stb   = (kind == K_RD);
        stat_stb = (kind == K_ST);
        #1 seen = bus_rdata;
        @(negedge clk);
        {sel_stb, cmd_stb, wr_stb, rd_stb, stat_stb} = '0;
        case (kind)
            K_SEL: begin m_wp = 0; m_sp = 0; end
            K_CMD: case (d[7:6])
                2'b01: m_step = 1;
                2'b10: m_step = 0;
                2'b11: m_step = ~m_step;
                default: ;
            endcase
            K_WR: begin
                m_disp[m_wp*8 +: 8] = d;
                if (m_step) m_wp = (m_wp + 1) % 4;
            end
            K_RD: m_sp = m_sp ^ 1;
            default: ;
        endcase
        if (kind == K_RD)      chk({req, " R7 read byte"}, {24'h0, seen}, {24'h0, exp_rd});
        else if (kind == K_ST) chk({req, " R8 status"}, {24'h0, seen}, {24'h0, exp_rd});
        else                   chk({req, " R9 idle bus"}, {24'h0, seen}, 32'h0);
        chk({req, " display"}, disp_out, m_disp);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 display cleared", disp_out, 32'h0);
        chk("R9 idle after reset", {24'h0, bus_rdata}, 32'h0);

        // R1/R6: fixed mode out of reset, writes pile into byte 0
        op(K_WR, 8'hA5, "R1 first write");
        op(K_WR, 8'h3C, "R6 fixed repeat");
        op(K_ST, 8'h00, "R8 status mid");

        // R3 sweep: each code from each starting mode, low bits varied
        for (int start = 0; start < 2; start++) begin
            for (int code = 0; code < 4; code++) begin
                op(K_CMD, start ? 8'h40 : 8'h80, "R3 set start");
                op(K_SEL, 8'h00, "R2 select");
                op(K_CMD, 8'((code << 6) | ((code * 13 + start * 7) & 8'h3F)), "R3 code");
                for (int w = 0; w < 5; w++)
                    op(K_WR, 8'(16 * code + 4 * start + w + 1), "R3 R5 R6 write run");
            end
        end

        // R4/R5: stepping walk with wrap twice
        op(K_CMD, 8'h7F, "R3 step");
        op(K_SEL, 8'h00, "R2 select");
        for (int w = 0; w < 9; w++) op(K_WR, 8'(8'hF0 ^ w), "R4 R5 walk");

        // R7: reads alternate; reads and writes keep separate pointers
        for (int v = 0; v < 8; v++) begin
            switch_in = 16'((v * 16'h1357) ^ 16'hA50F);
            op(K_RD, 8'h00, "R7 read");
            op(K_WR, 8'(v), "R7 write between reads");
            op(K_RD, 8'h00, "R7 read");
            op(K_RD, 8'h00, "R7 read third");
        end

        // R2: select mid-way returns both pointers home
        op(K_RD, 8'h00, "R7 read odd");
        op(K_WR, 8'h11, "R5 write");
        op(K_SEL, 8'h00, "R2 select mid");
        switch_in = 16'hBEEF;
        op(K_RD, 8'h00, "R2 read after select");
        op(K_WR, 8'h99, "R2 write after select");

        // R8: status changes nothing
        op(K_ST, 8'hFF, "R8 status");
        op(K_WR, 8'h77, "R8 pointer unchanged by status");
        op(K_RD, 8'h00, "R8 spos unchanged by status");

        // R1: reset again clears state
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        m_disp = '0; m_step = 0; m_wp = 0; m_sp = 0;
        chk("R1 display after reset", disp_out, 32'h0);
        op(K_RD, 8'h00, "R1 spos after reset");
        op(K_WR, 8'h5A, "R1 write after reset");
        op(K_WR, 8'h6B, "R1 fixed after reset");

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule